// File: doc/BRIEF.md
# Ping-Pong Transposing Sample Buffer

This block sits in front of a 128-point mixed-radix transform. It takes one complex sample (real and imaginary part) on every clock and writes it, in arrival order, into one 128-entry half of a two-half store. During the same clock it reads one sample from the other half, which holds the previous complete frame. The read order walks that frame column by column, treating the 128 samples as 8 rows of 16, so that a downstream 8-point engine receives each column's 8 samples back to back.

A start pulse aligns the block to the frame boundary. The sample presented with start becomes sample 0 of a new frame. Samples presented before the first start are not stored. Once a full frame has been written, the halves swap roles on every 128th clock. The stored frame then streams out with one clock of read latency. A single-cycle ready pulse marks the first output sample of each frame. Streaming continues without gaps until the next start or reset.

Top module: `pingpong_xpose_buf`

## Requirements
- R1: A synchronous active-high reset clears all state. In the cycle after reset, out_valid, frame_rdy, out_idx, out_re and out_im are all 0.
- R2: Before the first start pulse, input samples are ignored. Nothing is stored and out_valid stays 0.
- R3: Output j of a frame (j = 0..127, given on out_idx) carries the input sample with in-frame index 16·(j mod 8) + (j div 8), taken from the most recently completed frame. In bit terms, the read address is {j[2:0], j[6:3]}. The order therefore starts 0, 16, 32, …, 112, 1, 17, ….
- R4: Timing of the first frame: if start is sampled at clock edge E0, then output 0 of that frame is presented after edge E0+128 and output j after edge E0+128+j.
- R5: frame_rdy is high for exactly one cycle per frame. It coincides with out_valid = 1 and out_idx = 0.
- R6: Frames stream back to back. Once out_valid rises it stays high without gaps while no start or reset occurs, and frame_rdy repeats every 128 cycles.
- R7: A start pulse in mid-stream re-aligns the block. The partly written frame and the frame being read are discarded. out_valid is 0 from the cycle after the start until 128 new samples have been written, and the new frame then appears with the R4 timing.
- R8: While out_valid is 1, out_idx counts 0 to 127 and wraps to 0.
- R9: While out_valid is 0, out_re and out_im are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame alignment pulse; the sample presented with it becomes sample 0 |
| in_re | input | DATA_W | Real part of the incoming sample |
| in_im | input | DATA_W | Imaginary part of the incoming sample |
| out_re | output | DATA_W | Real part of the transposed output sample |
| out_im | output | DATA_W | Imaginary part of the transposed output sample |
| out_idx | output | 7 | Position of the current output within its frame |
| out_valid | output | 1 | Output sample is valid |
| frame_rdy | output | 1 | One-cycle pulse on the first output of each frame |

## Verification
The hardest situation to reach is a start pulse that lands while both halves are busy: one half is being read and the other is partly written. Such a start must discard both halves and restart the 128-cycle fill. The stimulus issues starts at several points: before any frame is complete, halfway through a read-out, and exactly on a frame boundary. A behavioural model that holds each frame as plain arrays predicts every output cycle. Each sample carries a value that encodes its frame and index, so a read from the wrong half or at the wrong address shows up as a data mismatch rather than passing unnoticed.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
  localparam int ROW_LG = 4;
  localparam int COL_LG = 3;
  localparam int IDX_W  = ROW_LG + COL_LG;
endpackage

// File: rtl/xbuf_seq.sv
module xbuf_seq #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic          rd_bank,
  output logic [AW-1:0] rd_cnt
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW-1:0] cnt_q;
  logic          bank_q;
  logic          run_q;
  logic          full_q;

  always_comb begin
    wr_addr = start ? '0 : cnt_q;
    wr_bank = start ? 1'b0 : bank_q;
    wr_en   = start | run_q;
    rd_en   = full_q & run_q & ~start;
    rd_bank = ~bank_q;
    rd_cnt  = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
      run_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (wr_en) begin
      cnt_q  <= wr_addr + 1'b1;
      run_q  <= 1'b1;
      bank_q <= (wr_addr == LAST) ? ~wr_bank : wr_bank;
      if (start)
        full_q <= 1'b0;
      else if (wr_addr == LAST)
        full_q <= 1'b1;
    end
  end

  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst)
    (run_q && !start) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_bank_swap_R6: assert property (@(posedge clk) disable iff (rst)
    (run_q && !start && cnt_q == LAST) |=> (bank_q != $past(bank_q)));

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> (!full_q && cnt_q == 1 && !bank_q));
endmodule

// File: rtl/xbuf_perm.sv
module xbuf_perm #(
  parameter int ROW_LG = 4,
  parameter int COL_LG = 3
) (
  input  logic [ROW_LG+COL_LG-1:0] idx,
  output logic [ROW_LG+COL_LG-1:0] addr
);
  genvar g;
  generate
    for (g = 0; g < ROW_LG; g++) begin : g_row
      assign addr[g] = idx[COL_LG + g];
    end
    for (g = 0; g < COL_LG; g++) begin : g_col
      assign addr[ROW_LG + g] = idx[g];
    end
  endgenerate
endmodule

// File: rtl/xbuf_mem.sv
module xbuf_mem #(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wre,
  input  logic [DW-1:0] wim,
  input  logic          re,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rre,
  output logic [DW-1:0] rim
);
  localparam int DEPTH = 2 << AW;

  logic [2*DW-1:0] mem [DEPTH];
  logic [2*DW-1:0] q;

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, waddr}] <= {wre, wim};
  end

  always_ff @(posedge clk) begin
    if (rst || !re) q <= '0;
    else            q <= mem[{rbank, raddr}];
  end

  assign rre = q[2*DW-1:DW];
  assign rim = q[DW-1:0];

  assert_no_collision_R3: assert property (@(posedge clk) disable iff (rst)
    (we && re) |-> (wbank != rbank));
endmodule

// File: rtl/pingpong_xpose_buf.sv
module pingpong_xpose_buf #(
  parameter int DATA_W = 16,
  parameter int ROW_LG = xbuf_pkg::ROW_LG,
  parameter int COL_LG = xbuf_pkg::COL_LG
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [DATA_W-1:0]        in_re,
  input  logic [DATA_W-1:0]        in_im,
  output logic [DATA_W-1:0]        out_re,
  output logic [DATA_W-1:0]        out_im,
  output logic [ROW_LG+COL_LG-1:0] out_idx,
  output logic                     out_valid,
  output logic                     frame_rdy
);
  localparam int AW = ROW_LG + COL_LG;

  logic          wr_en, wr_bank, rd_en, rd_bank;
  logic [AW-1:0] wr_addr, rd_cnt, rd_addr;

  xbuf_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_cnt(rd_cnt)
  );

  xbuf_perm #(.ROW_LG(ROW_LG), .COL_LG(COL_LG)) u_perm (
    .idx(rd_cnt), .addr(rd_addr)
  );

  xbuf_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .clk(clk), .rst(rst),
    .we(wr_en), .wbank(wr_bank), .waddr(wr_addr), .wre(in_re), .wim(in_im),
    .re(rd_en), .rbank(rd_bank), .raddr(rd_addr), .rre(out_re), .rim(out_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      frame_rdy <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= rd_en;
      frame_rdy <= rd_en && (rd_cnt == '0);
      out_idx   <= rd_en ? rd_cnt : '0;
    end
  end

  assert_rdy_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    frame_rdy |=> !frame_rdy);

  assert_rdy_first_R5: assert property (@(posedge clk) disable iff (rst)
    frame_rdy |-> (out_valid && out_idx == '0));

  assert_idx_step_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !frame_rdy) |-> (out_idx == $past(out_idx) + 1'b1));

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> !out_valid);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_re == '0 && out_im == '0));
endmodule

// File: tb/tb_pingpong_xpose_buf.sv
`timescale 1ns/1ps
module tb_pingpong_xpose_buf;
  localparam int DW = 16;
  localparam int N  = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic [DW-1:0] out_re, out_im;
  logic [6:0]    out_idx;
  logic          out_valid, frame_rdy;

  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pingpong_xpose_buf #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .start(start), .in_re(in_re), .in_im(in_im),
    .out_re(out_re), .out_im(out_im), .out_idx(out_idx),
    .out_valid(out_valid), .frame_rdy(frame_rdy)
  );

  // behavioural model
  int cur_re[N], cur_im[N], prv_re[N], prv_im[N];
  int m_cnt = 0; bit m_run = 0, m_full = 0;
  int e_re = 0, e_im = 0, e_idx = 0; bit e_val = 0, e_rdy = 0;
  int seq = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(bit s, bit r, int re, int im);
    if (r) begin
      m_cnt = 0; m_run = 0; m_full = 0;
      e_val = 0; e_rdy = 0; e_re = 0; e_im = 0; e_idx = 0;
      return;
    end
    if (m_full && m_run && !s) begin
      int a = (m_cnt % 8) * 16 + (m_cnt / 8);
      e_val = 1; e_rdy = (m_cnt == 0); e_idx = m_cnt;
      e_re = prv_re[a]; e_im = prv_im[a];
    end else begin
      e_val = 0; e_rdy = 0; e_idx = 0; e_re = 0; e_im = 0;
    end
    if (s || m_run) begin
      int a = s ? 0 : m_cnt;
      if (s) m_full = 0;
      cur_re[a] = re; cur_im[a] = im;
      if (a == N - 1) begin
        for (int k = 0; k < N; k++) begin
          prv_re[k] = cur_re[k]; prv_im[k] = cur_im[k];
        end
        m_full = 1;
      end
      m_cnt = (a + 1) % N;
      m_run = 1;
    end
  endtask

  // one clock: drive, edge, model, compare 2 ns after the edge
  task automatic step(bit s, bit r);
    int re = (seq * 37 + 5) & 16'hFFFF;
    int im = (seq * 11 + 4000) & 16'hFFFF;
    seq++;
    start = s; rst = r; in_re = re[DW-1:0]; in_im = im[DW-1:0];
    @(posedge clk);
    model_edge(s, r, re, im);
    #2;
    chk("R6/R7 out_valid", int'(out_valid), int'(e_val));
    chk("R5 frame_rdy", int'(frame_rdy), int'(e_rdy));
    chk("R8 out_idx", int'(out_idx), e_idx);
    chk("R3/R9 out_re", int'(out_re), e_re);
    chk("R3/R9 out_im", int'(out_im), e_im);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    #2;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    // R1: reset state
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 rdy after reset", int'(frame_rdy), 0);
    chk("R1 data after reset", int'(out_re) + int'(out_im) + int'(out_idx), 0);
    // R2: samples before any start are ignored
    run(20);
    chk("R2 idle before start", int'(out_valid), 0);
    // R4: first frame timing
    step(1'b1, 1'b0);
    run(127);
    chk("R4 not valid before fill", int'(out_valid), 0);
    step(1'b0, 1'b0);
    chk("R4 first output valid", int'(out_valid), 1);
    chk("R4 first output rdy", int'(frame_rdy), 1);
    // R6: continuous streaming across frames
    run(N * 2 + 63);
    // R7: start while reading mid-frame
    step(1'b1, 1'b0);
    chk("R7 restart drops valid", int'(out_valid), 0);
    run(N + 10);
    // R7: start exactly on a frame boundary
    run(N - 11);
    step(1'b1, 1'b0);
    run(N * 2 + 5);
    // R7: start before the first frame completes
    run(40);
    step(1'b1, 1'b0);
    run(60);
    step(1'b1, 1'b0);
    run(N * 2);
    // R1: reset during streaming
    step(1'b0, 1'b1);
    chk("R1 reset mid-stream", int'(out_valid), 0);
    run(N + 4);
    chk("R2 idle after reset", int'(out_valid), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule